// File: doc/BRIEF.md
# Cascadable Unsigned Magnitude Comparator

This block compares two unsigned words and raises exactly one of three flags: less-than, equal or greater-than. It is built from identical narrow slices, each of which looks at one group of bits of both operands. A slice decides the relation on its own when its two bit groups differ. When they are equal, it passes on the relation it receives from the slice below. Results therefore ripple from the least significant group to the most significant one, and the top slice's outputs are the block's outputs.

In the default configuration, three 4-bit slices form a 12-bit comparator. The slice width and the slice count are parameters. The path is purely combinational, so the flags follow the operands with no clock. The lowest slice's cascade inputs are tied to "equal" (less-than and greater-than low, equal high), so that identical words report equality.

Top module: `mag_cmp_chain`

## Requirements
- R1: `lt_o` is 1 exactly when `a_i` is below `b_i` as unsigned numbers.
- R2: `eq_o` is 1 exactly when `a_i` and `b_i` are bit-for-bit identical, including all-zero and all-one words; this comes from the equal tie-off on the lowest slice.
- R3: `gt_o` is 1 exactly when `a_i` is above `b_i` as unsigned numbers.
- R4: For every operand pair, exactly one of `lt_o`, `eq_o`, `gt_o` is 1.
- R5: When the most significant slice's bit groups differ, that difference alone sets the result, whatever the lower bits hold.
- R6: When all higher slices hold equal groups, the result is set by the highest lower slice whose groups differ, carried upward through the equal slices.
- R7: Inside one slice, the highest differing bit decides, so a difference in a group's top bit outweighs an opposite difference in its lower bits.
- R8: Operands that differ only in bit 0, or only in the top bit of the word, are ordered correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | SLICE_W*NSLICES (12) | First unsigned operand |
| b_i | input | SLICE_W*NSLICES (12) | Second unsigned operand |
| lt_o | output | 1 | a_i below b_i |
| eq_o | output | 1 | a_i equal to b_i |
| gt_o | output | 1 | a_i above b_i |

## Verification
The hardest case to reach from the ports is a decision made in the lowest slice that must ripple through every higher slice. This needs all upper groups to match exactly, which random operands almost never produce. The bench reaches this case on purpose. For each slice position, it gives both operands identical random bits above that slice, sweeps every pair of values within the slice, and fills the bits below with random data. This covers both the ripple path and the priority of each slice's own bits.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  // Relation between two operands, one-hot when valid.
  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
  } rel_t;

  localparam rel_t REL_EQUAL = '{lt: 1'b0, eq: 1'b1, gt: 1'b0};

endpackage

// File: rtl/mag_cmp_group.sv
// Relation of two bit groups, decided from the top bit downward.
module mag_cmp_group
  import mag_cmp_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] a,
  input  logic [GW-1:0] b,
  output rel_t          rel
);

  logic [GW-1:0] bit_eq;
  logic [GW-1:0] above_eq;   // all bits above position i match
  logic [GW-1:0] gt_term;
  logic [GW-1:0] lt_term;

  assign above_eq[GW-1] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < GW; i++) begin : g_bit
      assign bit_eq[i]  = ~(a[i] ^ b[i]);
      assign gt_term[i] = above_eq[i] & a[i] & ~b[i];
      assign lt_term[i] = above_eq[i] & ~a[i] & b[i];
      if (i < GW - 1) begin : g_chain
        assign above_eq[i] = above_eq[i+1] & bit_eq[i+1];
      end
    end
  endgenerate

  assign rel.gt = |gt_term;
  assign rel.lt = |lt_term;
  assign rel.eq = above_eq[0] & bit_eq[0];

endmodule

// File: rtl/mag_cmp_merge.sv
// Combine the local relation with the one received from below.
module mag_cmp_merge
  import mag_cmp_pkg::*;
(
  input  rel_t own,
  input  rel_t low,
  output rel_t res
);

  assign res.gt = own.gt | (own.eq & low.gt);
  assign res.lt = own.lt | (own.eq & low.lt);
  assign res.eq = own.eq & low.eq;

endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import mag_cmp_pkg::*;
#(
  parameter int SW = 4
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  rel_t          casc_in,
  output rel_t          casc_out
);

  rel_t local_rel;

  mag_cmp_group #(.GW(SW)) u_grp (
    .a   (a),
    .b   (b),
    .rel (local_rel)
  );

  mag_cmp_merge u_mrg (
    .own (local_rel),
    .low (casc_in),
    .res (casc_out)
  );

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int SLICE_W = 4,
  parameter int NSLICES = 3,
  localparam int W = SLICE_W * NSLICES
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         lt_o,
  output logic         eq_o,
  output logic         gt_o
);

  rel_t link [NSLICES+1];

  // Lowest stage sees "equal so far".
  assign link[0] = REL_EQUAL;

  genvar s;
  generate
    for (s = 0; s < NSLICES; s++) begin : g_slice
      mag_cmp_slice #(.SW(SLICE_W)) u_slice (
        .a        (a_i[s*SLICE_W +: SLICE_W]),
        .b        (b_i[s*SLICE_W +: SLICE_W]),
        .casc_in  (link[s]),
        .casc_out (link[s+1])
      );
    end
  endgenerate

  assign lt_o = link[NSLICES].lt;
  assign eq_o = link[NSLICES].eq;
  assign gt_o = link[NSLICES].gt;

endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int W = 12
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         lt_o,
  input logic         eq_o,
  input logic         gt_o
);

  always_comb begin
    if (!$isunknown({a_i, b_i, lt_o, eq_o, gt_o})) begin
      // R4
      one_flag_chk: assert ($countones({lt_o, eq_o, gt_o}) == 1);
      // R1
      below_chk: assert (lt_o == (a_i < b_i));
      // R2
      same_chk: assert (eq_o == (a_i == b_i));
      // R3
      above_chk: assert (gt_o == (a_i > b_i));
    end
  end

endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.W(W)) u_chk (
  .a_i  (a_i),
  .b_i  (b_i),
  .lt_o (lt_o),
  .eq_o (eq_o),
  .gt_o (gt_o)
);

// File: tb/sim_mag_cmp_chain.sv
module sim_mag_cmp_chain;

  localparam int SW = 4;
  localparam int NS = 3;
  localparam int W  = SW * NS;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a   = '0;
  logic [W-1:0] b   = '0;
  logic         lt, eq, gt;
  int           checks = 0;
  int           failures = 0;
  int           cycles = 0;
  bit           done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  mag_cmp_chain #(.SLICE_W(SW), .NSLICES(NS)) u0 (
    .a_i  (a),
    .b_i  (b),
    .lt_o (lt),
    .eq_o (eq),
    .gt_o (gt)
  );

  task automatic check_pair(input logic [W-1:0] av, input logic [W-1:0] bv,
                            input string req);
    logic [2:0] exp_f, act_f;
    a = av;
    b = bv;
    #1;
    exp_f = {(av < bv), (av == bv), (av > bv)};
    act_f = {lt, eq, gt};
    checks++;
    if (act_f !== exp_f) begin
      failures++;
      $display("FAIL %s a=%h b=%h lt/eq/gt actual=%b expected=%b",
               req, av, bv, act_f, exp_f);
    end
    checks++;
    if ($countones(act_f) != 1) begin
      failures++;
      $display("FAIL R4 a=%h b=%h actual flags=%b expected one-hot", av, bv, act_f);
    end
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        failures++;
        checks++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] ra, rb, hi_mask, lo_mask;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2: equal words, including both extremes
    check_pair('0, '0, "R2");
    check_pair('1, '1, "R2");
    check_pair(12'h5A3, 12'h5A3, "R2");

    // R8: difference only in bit 0 or only in the top bit
    check_pair(12'h000, 12'h001, "R8");
    check_pair(12'h001, 12'h000, "R8");
    check_pair(12'h7FF, 12'hFFF, "R8");
    check_pair(12'hFFF, 12'h7FF, "R8");
    check_pair(12'hABE, 12'hABF, "R8");

    // R7: group top bit beats opposite lower bits in the same group
    check_pair(12'h080, 12'h070, "R7");
    check_pair(12'h070, 12'h080, "R7");
    check_pair(12'h008, 12'h007, "R7");

    // R5: top group differs, lower bits opposite
    check_pair(12'h100, 12'h0FF, "R5");
    check_pair(12'h0FF, 12'h100, "R5");
    for (int k = 0; k < 2000; k++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      if (ra[W-1 -: SW] == rb[W-1 -: SW]) rb[W-1 -: SW] = ~ra[W-1 -: SW];
      check_pair(ra, rb, "R5");
    end

    // R6/R7: per slice, equal bits above, all value pairs in the slice,
    // random bits below
    for (int s = 0; s < NS; s++) begin
      hi_mask = '1 << ((s + 1) * SW);
      lo_mask = (W'(1) << (s * SW)) - W'(1);
      for (int x = 0; x < (1 << SW); x++) begin
        for (int y = 0; y < (1 << SW); y++) begin
          ra = W'($urandom);
          rb = (ra & hi_mask) | (W'($urandom) & lo_mask);
          ra = (ra & (hi_mask | lo_mask)) | (W'(x) << (s * SW));
          rb = rb | (W'(y) << (s * SW));
          check_pair(ra, rb, "R6");
        end
      end
    end

    // R1/R2/R3: fully random operands
    for (int k = 0; k < 8000; k++) begin
      check_pair(W'($urandom), W'($urandom), "R1/R3");
    end
    for (int k = 0; k < 500; k++) begin
      ra = W'($urandom);
      check_pair(ra, ra, "R2");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule